// File: doc/BRIEF.md
# Relative Branch Resolver with Alignment Checking

This block resolves a conditional program-relative branch in one registered step. A strobe delivers five things: the address of the branch instruction, a 4-bit condition selector, a signed byte displacement, a flag that says whether the branch uses a trailing extension word, and the negative, zero and overflow condition flags. The block decides whether the branch is taken. It then loads the program counter that follows and reports a taken indication. It also raises an error when that program counter would fetch an operation word from an odd address.

The program counter is kept at its full 32-bit width and wraps modulo 2^32. Only its low 24 bits form the memory address that is actually driven, and that address is brought out on its own port.

A second, independent port checks any memory access for alignment. It takes an address, an access size and a flag that marks the access as an instruction fetch. One cycle later it reports whether the access breaks the even-address rule.

Top module: `brtgt_unit`

## Requirements
- R1: `br_done_o` is high in exactly the cycle after each cycle in which `br_valid_i` is high, and `chk_done_o` likewise follows `chk_valid_i` by one cycle; back-to-back strobes each produce one result.
- R2: The taken decision depends on the condition selector as follows. Code 0 is always taken and code 1 is never taken. Code 6 is taken when Z=0 and code 7 when Z=1. Code 12 is taken when N equals V, and code 13 when N differs from V. Every other code is not taken.
- R3: When taken, `next_pc_o` equals the branch address plus 2 plus the 16-bit displacement sign-extended to 32 bits, modulo 2^32. The extension-word flag has no effect on a taken branch.
- R4: When not taken, `next_pc_o` equals the branch address plus 2 if `br_ext_i` is 0, or plus 4 if `br_ext_i` is 1, modulo 2^32.
- R5: `fetch_addr_o` always equals bits 23:0 of `next_pc_o`, so address bits above 23 never reach it.
- R6: With each branch result, `br_err_o` is 1 exactly when the loaded program counter is odd, whether the branch was taken or not.
- R7: On the check port, `chk_size_i` encodes 0 = byte, 1 = word, 2 = long and 3 = long. `addr_err_o` is 1 exactly when bit 0 of `chk_addr_i` is 1 and either the size is not byte or `chk_fetch_i` is 1. An odd byte data access gives no error.
- R8: While no branch strobe arrives, `next_pc_o`, `taken_o` and `br_err_o` hold their last values.
- R9: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | Branch request strobe |
| br_addr_i | input | 32 | Address of the branch instruction |
| br_cond_i | input | 4 | Condition selector |
| br_disp_i | input | 16 | Signed byte displacement |
| br_ext_i | input | 1 | Branch carries an extension word |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| br_done_o | output | 1 | Branch result valid |
| taken_o | output | 1 | Branch was taken |
| next_pc_o | output | 32 | Program counter after the branch |
| fetch_addr_o | output | 24 | Significant memory address of `next_pc_o` |
| br_err_o | output | 1 | Next operation-word fetch is misaligned |
| chk_valid_i | input | 1 | Alignment check strobe |
| chk_addr_i | input | 32 | Address of the access to check |
| chk_size_i | input | 2 | Access size code |
| chk_fetch_i | input | 1 | Access is an instruction fetch |
| chk_done_o | output | 1 | Check result valid |
| addr_err_o | output | 1 | Access is misaligned |

## Verification
The branch side is swept over all sixteen condition selectors against all eight combinations of the N, Z and V flags. This sweep separates the code table cell by cell and shows that unlisted codes never take the branch. The extension flag is toggled through the same sweep, so the fall-through offset is checked on both taken and not-taken results.

Directed branches cover further cases:
- negative and most-negative displacements, which expose a missing sign extension;
- a target that wraps past 2^32, which exposes an adder that saturates or truncates;
- an address with high bits set, which checks that the 24-bit fetch address drops them;
- odd targets and odd instruction addresses, which check the fetch error on both outcomes.

The check port is tried with every size code, with and without the fetch flag, at an even and an odd address. This tells the byte exemption apart from the rule that a fetch must be even.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

   // Width of the branch condition selector.
   localparam int unsigned COND_W = 4;

   // Condition selector codes that can take a branch.
   localparam logic [COND_W-1:0] CC_ALWAYS = 4'd0;
   localparam logic [COND_W-1:0] CC_NEVER  = 4'd1;
   localparam logic [COND_W-1:0] CC_NE     = 4'd6;
   localparam logic [COND_W-1:0] CC_EQ     = 4'd7;
   localparam logic [COND_W-1:0] CC_GE     = 4'd12;
   localparam logic [COND_W-1:0] CC_LT     = 4'd13;

   // Byte length of an operation word and of one extension word.
   localparam int unsigned OP_WORD_BYTES = 2;

   // Access size codes on the check port.
   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_WORD = 2'd1,
      ACC_LONG = 2'd2,
      ACC_WIDE = 2'd3
   } acc_size_e;

endpackage

// File: rtl/brtgt_cond_eval.sv
module brtgt_cond_eval
   import brtgt_pkg::*;
(
   input  logic [COND_W-1:0] cond_i,
   input  logic              n_i,
   input  logic              z_i,
   input  logic              v_i,
   output logic              take_o
);

   always_comb begin
      unique case (cond_i)
         CC_ALWAYS: take_o = 1'b1;
         CC_NEVER:  take_o = 1'b0;
         CC_NE:     take_o = ~z_i;
         CC_EQ:     take_o = z_i;
         CC_GE:     take_o = ~(n_i ^ v_i);
         CC_LT:     take_o = n_i ^ v_i;
         default:   take_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/brtgt_target_add.sv
module brtgt_target_add
   import brtgt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DISP_W = 16
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              ext_i,
   input  logic              take_i,
   output logic [ADDR_W-1:0] next_o
);

   localparam logic [ADDR_W-1:0] BASE_OFS = ADDR_W'(OP_WORD_BYTES);
   localparam logic [ADDR_W-1:0] LONG_OFS = ADDR_W'(2 * OP_WORD_BYTES);

   logic [ADDR_W-1:0] disp_x;
   logic [ADDR_W-1:0] tgt;
   logic [ADDR_W-1:0] fall;

   // Widen the displacement; the variant depends on the width ratio.
   generate
      if (DISP_W == ADDR_W) begin : g_same_w
         assign disp_x = disp_i;
      end else begin : g_sext
         assign disp_x = {{(ADDR_W - DISP_W){disp_i[DISP_W-1]}}, disp_i};
      end
   endgenerate

   // Both candidates are formed in parallel; the decision only selects.
   assign tgt    = pc_i + BASE_OFS + disp_x;
   assign fall   = pc_i + (ext_i ? LONG_OFS : BASE_OFS);
   assign next_o = take_i ? tgt : fall;

endmodule

// File: rtl/brtgt_align_chk.sv
module brtgt_align_chk
   import brtgt_pkg::*;
(
   input  logic      lsb_i,
   input  acc_size_e size_i,
   input  logic      fetch_i,
   output logic      err_o
);

   logic needs_even;

   // Only byte data may sit on an odd address.
   assign needs_even = fetch_i | (size_i != ACC_BYTE);
   assign err_o      = lsb_i & needs_even;

endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
   import brtgt_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SIG_W  = 24,
   parameter int unsigned DISP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid_i,
   input  logic [ADDR_W-1:0] br_addr_i,
   input  logic [COND_W-1:0] br_cond_i,
   input  logic [DISP_W-1:0] br_disp_i,
   input  logic              br_ext_i,
   input  logic              flag_n_i,
   input  logic              flag_z_i,
   input  logic              flag_v_i,
   output logic              br_done_o,
   output logic              taken_o,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic [SIG_W-1:0]  fetch_addr_o,
   output logic              br_err_o,
   input  logic              chk_valid_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   input  logic [1:0]        chk_size_i,
   input  logic              chk_fetch_i,
   output logic              chk_done_o,
   output logic              addr_err_o
);

   // Elaboration-time parameter checks.
   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("brtgt_unit: ADDR_W must be at least 2");
      end
      if (SIG_W > ADDR_W || SIG_W < 1) begin : g_bad_sig_w
         $error("brtgt_unit: SIG_W must lie in 1..ADDR_W");
      end
      if (DISP_W > ADDR_W || DISP_W < 2) begin : g_bad_disp_w
         $error("brtgt_unit: DISP_W must lie in 2..ADDR_W");
      end
   endgenerate

   logic              take_c;
   logic [ADDR_W-1:0] next_c;
   logic              pc_err_c;
   logic              acc_err_c;
   logic              chk_hi_unused;

   logic              br_done_q;
   logic              taken_q;
   logic [ADDR_W-1:0] next_q;
   logic              br_err_q;
   logic              chk_done_q;
   logic              acc_err_q;

   brtgt_cond_eval u_cond (
      .cond_i (br_cond_i),
      .n_i    (flag_n_i),
      .z_i    (flag_z_i),
      .v_i    (flag_v_i),
      .take_o (take_c)
   );

   brtgt_target_add #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_add (
      .pc_i   (br_addr_i),
      .disp_i (br_disp_i),
      .ext_i  (br_ext_i),
      .take_i (take_c),
      .next_o (next_c)
   );

   // The next program counter is checked as an operation-word fetch.
   brtgt_align_chk u_pc_align (
      .lsb_i   (next_c[0]),
      .size_i  (ACC_WORD),
      .fetch_i (1'b1),
      .err_o   (pc_err_c)
   );

   brtgt_align_chk u_acc_align (
      .lsb_i   (chk_addr_i[0]),
      .size_i  (acc_size_e'(chk_size_i)),
      .fetch_i (chk_fetch_i),
      .err_o   (acc_err_c)
   );

   // Upper address bits do not affect alignment.
   assign chk_hi_unused = ^chk_addr_i[ADDR_W-1:1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         br_done_q  <= 1'b0;
         taken_q    <= 1'b0;
         next_q     <= '0;
         br_err_q   <= 1'b0;
         chk_done_q <= 1'b0;
         acc_err_q  <= 1'b0;
      end else begin
         br_done_q  <= br_valid_i;
         chk_done_q <= chk_valid_i;
         if (br_valid_i) begin
            taken_q  <= take_c;
            next_q   <= next_c;
            br_err_q <= pc_err_c;
         end
         if (chk_valid_i) begin
            acc_err_q <= acc_err_c;
         end
      end
   end

   assign br_done_o    = br_done_q;
   assign taken_o      = taken_q;
   assign next_pc_o    = next_q;
   assign fetch_addr_o = next_q[SIG_W-1:0];
   assign br_err_o     = br_err_q;
   assign chk_done_o   = chk_done_q;
   assign addr_err_o   = acc_err_q;

endmodule

// File: rtl/brtgt_unit_chk.sv
module brtgt_unit_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DISP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              br_valid_i,
   input logic [ADDR_W-1:0] br_addr_i,
   input logic [3:0]        br_cond_i,
   input logic [DISP_W-1:0] br_disp_i,
   input logic              br_ext_i,
   input logic              br_done_o,
   input logic              taken_o,
   input logic [ADDR_W-1:0] next_pc_o,
   input logic              br_err_o,
   input logic              chk_valid_i,
   input logic              chk_lsb_i,
   input logic [1:0]        chk_size_i,
   input logic              chk_fetch_i,
   input logic              chk_done_o,
   input logic              addr_err_o
);

   logic [ADDR_W-1:0] disp_x;
   assign disp_x = ADDR_W'(signed'(br_disp_i));

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid_i |=> br_done_o);

   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid_i |=> !br_done_o);

   p_chk_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_i |=> chk_done_o);

   p_never_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_cond_i == 4'd1) |=> !taken_o);

   p_always_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_cond_i == 4'd0) |=>
         (taken_o && next_pc_o == $past(br_addr_i) + ADDR_W'(2) + $past(disp_x)));

   p_fall_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_cond_i == 4'd1) |=>
         (next_pc_o == $past(br_addr_i) + ($past(br_ext_i) ? ADDR_W'(4) : ADDR_W'(2))));

   p_pc_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      br_done_o |-> (br_err_o == next_pc_o[0]));

   p_byte_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid_i && chk_size_i == 2'd0 && !chk_fetch_i) |=> !addr_err_o);

   p_even_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid_i && !chk_lsb_i) |=> !addr_err_o);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(br_err_o)));

endmodule

bind brtgt_unit brtgt_unit_chk #(
   .ADDR_W (ADDR_W),
   .DISP_W (DISP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .br_valid_i  (br_valid_i),
   .br_addr_i   (br_addr_i),
   .br_cond_i   (br_cond_i),
   .br_disp_i   (br_disp_i),
   .br_ext_i    (br_ext_i),
   .br_done_o   (br_done_o),
   .taken_o     (taken_o),
   .next_pc_o   (next_pc_o),
   .br_err_o    (br_err_o),
   .chk_valid_i (chk_valid_i),
   .chk_lsb_i   (chk_addr_i[0]),
   .chk_size_i  (chk_size_i),
   .chk_fetch_i (chk_fetch_i),
   .chk_done_o  (chk_done_o),
   .addr_err_o  (addr_err_o)
);

// File: tb/brtgt_unit_tb_top.sv
`timescale 1ns/1ps
module brtgt_unit_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        br_valid_i;
   logic [31:0] br_addr_i;
   logic [3:0]  br_cond_i;
   logic [15:0] br_disp_i;
   logic        br_ext_i;
   logic        flag_n_i, flag_z_i, flag_v_i;
   logic        br_done_o, taken_o, br_err_o;
   logic [31:0] next_pc_o;
   logic [23:0] fetch_addr_o;
   logic        chk_valid_i;
   logic [31:0] chk_addr_i;
   logic [1:0]  chk_size_i;
   logic        chk_fetch_i;
   logic        chk_done_o, addr_err_o;

   brtgt_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .br_valid_i(br_valid_i), .br_addr_i(br_addr_i), .br_cond_i(br_cond_i),
      .br_disp_i(br_disp_i), .br_ext_i(br_ext_i),
      .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_v_i(flag_v_i),
      .br_done_o(br_done_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
      .fetch_addr_o(fetch_addr_o), .br_err_o(br_err_o),
      .chk_valid_i(chk_valid_i), .chk_addr_i(chk_addr_i), .chk_size_i(chk_size_i),
      .chk_fetch_i(chk_fetch_i), .chk_done_o(chk_done_o), .addr_err_o(addr_err_o)
   );

   typedef struct packed {
      logic [31:0] pc;
      logic        tk;
      logic        er;
   } br_exp_t;

   br_exp_t br_q[$];
   string   br_tag_q[$];
   logic    chk_q[$];
   string   chk_tag_q[$];

   int          n_run  = 0;
   int          n_fail = 0;
   logic [31:0] last_pc = '0;
   logic        last_tk = 1'b0;
   logic        last_er = 1'b0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic ref_take(logic [3:0] c, logic n, logic z, logic v);
      case (c)
         4'd0:    return 1'b1;
         4'd6:    return !z;
         4'd7:    return z;
         4'd12:   return n == v;
         4'd13:   return n != v;
         default: return 1'b0;
      endcase
   endfunction

   // Driver: present one branch request and push its expected result.
   task automatic drv_br(logic [31:0] a, logic [3:0] c, logic [15:0] d,
                         logic e, logic n, logic z, logic v, string tag);
      br_exp_t x;
      @(negedge clk);
      br_valid_i = 1'b1; br_addr_i = a; br_cond_i = c; br_disp_i = d;
      br_ext_i = e; flag_n_i = n; flag_z_i = z; flag_v_i = v;
      x.tk = ref_take(c, n, z, v);
      if (x.tk) x.pc = a + 32'd2 + 32'(signed'(d));
      else      x.pc = a + (e ? 32'd4 : 32'd2);
      x.er = x.pc[0];
      last_pc = x.pc; last_tk = x.tk; last_er = x.er;
      br_q.push_back(x);
      br_tag_q.push_back(tag);
   endtask

   task automatic drv_chk(logic [31:0] a, logic [1:0] s, logic f);
      @(negedge clk);
      chk_valid_i = 1'b1; chk_addr_i = a; chk_size_i = s; chk_fetch_i = f;
      chk_q.push_back(a[0] && (s != 2'd0 || f));
      chk_tag_q.push_back("R7 check port");
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         br_valid_i  = 1'b0;
         chk_valid_i = 1'b0;
      end
   endtask

   // Monitor: pop and compare as results appear.
   always @(negedge clk) begin
      if (rst_n) begin
         if (br_done_o) begin
            if (br_q.size() == 0) begin
               check("R1 unexpected branch result", 32'd1, 32'd0);
            end else begin
               br_exp_t x;
               string   t;
               x = br_q.pop_front();
               t = br_tag_q.pop_front();
               check({t, " R3/R4 next pc"}, next_pc_o, x.pc);
               check({t, " R2 taken"}, {31'd0, taken_o}, {31'd0, x.tk});
               check({t, " R6 fetch error"}, {31'd0, br_err_o}, {31'd0, x.er});
               check({t, " R5 fetch address"}, {8'd0, fetch_addr_o}, {8'd0, x.pc[23:0]});
            end
         end
         if (chk_done_o) begin
            if (chk_q.size() == 0) begin
               check("R1 unexpected check result", 32'd1, 32'd0);
            end else begin
               logic  e;
               string t;
               e = chk_q.pop_front();
               t = chk_tag_q.pop_front();
               check(t, {31'd0, addr_err_o}, {31'd0, e});
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      br_valid_i = 0; br_addr_i = 0; br_cond_i = 0; br_disp_i = 0; br_ext_i = 0;
      flag_n_i = 0; flag_z_i = 0; flag_v_i = 0;
      chk_valid_i = 0; chk_addr_i = 0; chk_size_i = 0; chk_fetch_i = 0;
      repeat (3) @(negedge clk);
      check("R9 reset br_done", {31'd0, br_done_o}, 32'd0);
      check("R9 reset taken", {31'd0, taken_o}, 32'd0);
      check("R9 reset next_pc", next_pc_o, 32'd0);
      check("R9 reset fetch_addr", {8'd0, fetch_addr_o}, 32'd0);
      check("R9 reset errors", {30'd0, br_err_o, addr_err_o}, 32'd0);
      check("R9 reset chk_done", {31'd0, chk_done_o}, 32'd0);
      rst_n = 1'b1;
      idle(2);

      // R2 sweep: every code against every N/Z/V combination, back to back.
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 8; f++) begin
            drv_br(32'h0000_1000 + 32'(c * 256 + f * 16), 4'(c), 16'h0020,
                   f[0] ^ c[0], f[2], f[1], f[0], "R2 code sweep");
         end
      end
      idle(2);

      // R3 negative, most-negative and wrapping displacements.
      drv_br(32'h0000_2000, 4'd0, 16'hFFF0, 1'b0, 0, 0, 0, "R3 negative disp");
      drv_br(32'h0001_0000, 4'd0, 16'h8000, 1'b0, 0, 0, 0, "R3 most negative disp");
      drv_br(32'hFFFF_FFF0, 4'd0, 16'h0020, 1'b0, 0, 0, 0, "R3 wrap past 2^32");
      drv_br(32'h0000_0400, 4'd7, 16'h0100, 1'b1, 0, 1, 0, "R3 ext ignored when taken");
      // R4 fall-through with and without extension word.
      drv_br(32'h0000_0200, 4'd7, 16'h0100, 1'b1, 0, 0, 0, "R4 ext fall-through");
      drv_br(32'h0000_0200, 4'd13, 16'h0100, 1'b0, 1, 0, 1, "R4 short fall-through");
      drv_br(32'hFFFF_FFFE, 4'd1, 16'h0000, 1'b1, 0, 0, 0, "R4 fall-through wrap");
      // R5 high bits dropped from the fetch address.
      drv_br(32'h12FF_FFFC, 4'd0, 16'h0004, 1'b0, 0, 0, 0, "R5 high bits");
      // R6 odd results.
      drv_br(32'h0000_0100, 4'd0, 16'h0003, 1'b0, 0, 0, 0, "R6 odd target");
      drv_br(32'h0000_0100, 4'd1, 16'h0003, 1'b0, 0, 0, 0, "R6 odd target not taken");
      drv_br(32'h0000_0301, 4'd1, 16'h0000, 1'b0, 0, 0, 0, "R6 odd instruction address");
      idle(1);

      // R8 outputs hold while idle.
      idle(3);
      check("R8 next_pc held", next_pc_o, last_pc);
      check("R8 taken held", {31'd0, taken_o}, {31'd0, last_tk});
      check("R8 error held", {31'd0, br_err_o}, {31'd0, last_er});

      // R7 every size, fetch flag and address parity.
      for (int p = 0; p < 2; p++) begin
         for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 2; f++) begin
               drv_chk(32'hABCD_0010 + 32'(p), 2'(s), f[0]);
            end
         end
      end
      idle(3);

      check("R1 branch results outstanding", 32'(br_q.size()), 32'd0);
      check("R1 check results outstanding", 32'(chk_q.size()), 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule